// File: doc/BRIEF.md
# Hashed DRAM-to-Normalized Address Converter

This block turns a 28-bit error address given in DRAM coordinates into the 31-bit normalized address that the memory controller uses for its own view of memory. The DRAM coordinates are stack, pseudochannel, row, bank and column. The controller scrambles the bank and pseudochannel bits with an XOR hash of row and column bits. The converter first reverses that hash and then places the fields into the fixed, interleaved normalized layout.

The hash settings are kept in six configuration registers: four bank-hash words, one pseudochannel-hash word and one small bank-XOR mask. They are loaded over a single-cycle register-write port and are expected to stay unchanged while conversions run. Requests enter through a valid/ready handshake. The converted address comes out of a register one clock after acceptance. While the consumer keeps ready high, one request is accepted on every cycle.

Top module: `dram_addr_normalizer`

## Requirements
- R1: Input field positions in `in_addr`: bit 0 is unused, column[4:0] at 5:1, bank[3:0] at 9:6, row[14:0] at 24:10, pseudochannel at 25, stack[1:0] at 27:26.
- R2: Output layout of `out_addr`: 4:0 zero, 6:5 column[1:0], 7 pseudochannel, 9:8 column[3:2], 11:10 bank[3:2], 13:12 bank[1:0], 14 column[4], 28:15 row[13:0], 30:29 stack[1:0]. Row[14] is discarded. With every hash enable clear, the output is this repack of the input fields unchanged.
- R3: For each bank bit i (0..3), when bank-hash word i has its enable set, bank[i] is inverted by parity(column AND column mask) XOR parity(row AND row mask) of that word.
- R4: When the pseudochannel-hash word is enabled, the pseudochannel bit is inverted by the XOR of three parities: column AND its mask, row AND its mask, and extended bank AND the bank-XOR mask. The extended bank uses the already de-hashed bank bits.
- R5: The extended bank is {stack[1:0], 0, bank[3:0]}, with stack at positions 6:5. The bank-XOR mask covers positions 5:0 only, so stack[1] never takes part. The stack bits never change the bank value that is packed into the output.
- R6: A hash word has its enable at bit 0, a 13-bit column mask at 13:1 and an 18-bit row mask at 31:14. Mask bits above the width of the field they apply to (column 5, row 15) have no effect.
- R7: A configuration write with `cfg_idx` 0..3 loads bank-hash word 0..3, index 4 loads the pseudochannel-hash word, and index 5 loads the bank-XOR mask from data bits 5:0. Indices 6 and 7 change nothing. All registers reset to zero, which disables hashing.
- R8: A request accepted on a clock edge (`in_valid` and `in_ready` high) presents its result with `out_valid` high after that same edge. `out_valid` is low after reset.
- R9: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_addr` and `out_valid` hold.
- R10: With `out_ready` held high, requests on consecutive cycles are each accepted and produce results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Conversion request valid |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | 28 | DRAM-form error address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_addr | output | 31 | Normalized address |

## Verification
The hardest case to reach from the ports is the one where the pseudochannel hash depends on a bank bit that the bank hash has just flipped, together with the case where stack[0] enters that hash through the borrowed bank position. Directed vectors program one bank-hash word with a single column mask bit and set the bank-XOR mask to that bank bit or to the stack position, so that every flipped output bit follows from exactly one known cause. Randomized masks and addresses are then checked against an independent bit-by-bit model. That run also mixes in writes to the unused indices, and backpressure sequences check that a stalled result holds.

// File: rtl/adn_pkg.sv
package adn_pkg;

   localparam int HASH_WORD_W = 32;
   localparam int COL_MASK_W  = 13;
   localparam int ROW_MASK_W  = 18;

   typedef struct packed {
      logic [ROW_MASK_W-1:0] row_mask;
      logic [COL_MASK_W-1:0] col_mask;
      logic                  en;
   } hash_word_t;

endpackage

// File: rtl/adn_cfg_regs.sv
module adn_cfg_regs
   import adn_pkg::*;
#(
   parameter int NUM_BANK_HASH = 4,
   parameter int IDX_W         = 3,
   parameter int DATA_W        = 32,
   parameter int BXOR_W        = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [IDX_W-1:0]              idx_i,
   input  logic [DATA_W-1:0]             wdata_i,
   output hash_word_t [NUM_BANK_HASH-1:0] bank_hash_o,
   output hash_word_t                    pc_hash_o,
   output logic [BXOR_W-1:0]             bank_xor_o
);

   localparam int PC_IDX   = NUM_BANK_HASH;
   localparam int BXOR_IDX = NUM_BANK_HASH + 1;

   generate
      if (DATA_W != HASH_WORD_W) begin : g_bad_data_w
         $error("adn_cfg_regs: DATA_W must equal the hash word width");
      end
      if ((1 << IDX_W) < NUM_BANK_HASH + 2) begin : g_bad_idx_w
         $error("adn_cfg_regs: IDX_W too small for register count");
      end
      if (BXOR_W > DATA_W) begin : g_bad_bxor_w
         $error("adn_cfg_regs: BXOR_W exceeds data width");
      end
   endgenerate

   for (genvar g = 0; g < NUM_BANK_HASH; g++) begin : g_bank_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_hash_o[g] <= '0;
         else if (we_i && (int'(idx_i) == g))
            bank_hash_o[g] <= hash_word_t'(wdata_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_hash_o  <= '0;
         bank_xor_o <= '0;
      end else if (we_i) begin
         if (int'(idx_i) == PC_IDX)   pc_hash_o  <= hash_word_t'(wdata_i);
         if (int'(idx_i) == BXOR_IDX) bank_xor_o <= wdata_i[BXOR_W-1:0];
      end
   end

   // Writes to unused indices leave every register untouched.
   p_unused_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && (int'(idx_i) > BXOR_IDX)) |=>
         ($stable(bank_hash_o) && $stable(pc_hash_o) && $stable(bank_xor_o)));

endmodule

// File: rtl/adn_dehash.sv
module adn_dehash
   import adn_pkg::*;
#(
   parameter int NUM_BANK_HASH = 4,
   parameter int COL_W         = 5,
   parameter int ROW_W         = 15,
   parameter int STK_W         = 2,
   parameter int BXOR_W        = 6
) (
   input  logic [COL_W-1:0]               col_i,
   input  logic [ROW_W-1:0]               row_i,
   input  logic [NUM_BANK_HASH-1:0]       bank_i,
   input  logic                           pc_i,
   input  logic [STK_W-1:0]               stk_i,
   input  hash_word_t [NUM_BANK_HASH-1:0] bank_hash_i,
   input  hash_word_t                     pc_hash_i,
   input  logic [BXOR_W-1:0]              bank_xor_i,
   output logic [NUM_BANK_HASH-1:0]       bank_o,
   output logic                           pc_o
);

   // Extended bank: {stack, one zero gap bit, bank}.
   localparam int EXT_W = NUM_BANK_HASH + 1 + STK_W;

   generate
      if (COL_W > COL_MASK_W) begin : g_bad_col_w
         $error("adn_dehash: COL_W wider than column mask");
      end
      if (ROW_W > ROW_MASK_W) begin : g_bad_row_w
         $error("adn_dehash: ROW_W wider than row mask");
      end
      if (BXOR_W > EXT_W) begin : g_bad_bxor_w
         $error("adn_dehash: BXOR_W wider than extended bank");
      end
   endgenerate

   logic [COL_MASK_W-1:0] col_ext;
   logic [ROW_MASK_W-1:0] row_ext;
   assign col_ext = COL_MASK_W'(col_i);
   assign row_ext = ROW_MASK_W'(row_i);

   for (genvar g = 0; g < NUM_BANK_HASH; g++) begin : g_bank_bit
      logic flip;
      assign flip = bank_hash_i[g].en &
                    ((^(col_ext & bank_hash_i[g].col_mask)) ^
                     (^(row_ext & bank_hash_i[g].row_mask)));
      assign bank_o[g] = bank_i[g] ^ flip;
   end

   logic [EXT_W-1:0] bank_ext;
   logic [EXT_W-1:0] bxor_mask;
   logic             pc_flip;
   assign bank_ext  = {stk_i, 1'b0, bank_o};
   assign bxor_mask = EXT_W'(bank_xor_i);
   assign pc_flip   = pc_hash_i.en &
                      ((^(col_ext & pc_hash_i.col_mask)) ^
                       (^(row_ext & pc_hash_i.row_mask)) ^
                       (^(bank_ext & bxor_mask)));
   assign pc_o = pc_i ^ pc_flip;

   // A bank bit only changes when its hash word is enabled.
   always_comb begin
      for (int i = 0; i < NUM_BANK_HASH; i++) begin
         p_bank_needs_enable_r3: assert (bank_hash_i[i].en || (bank_o[i] == bank_i[i]));
      end
      p_pc_needs_enable_r4: assert (pc_hash_i.en || (pc_o == pc_i));
   end

endmodule

// File: rtl/dram_addr_normalizer.sv
module dram_addr_normalizer
   import adn_pkg::*;
#(
   parameter int ROW_W = 15,
   parameter int STK_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [2:0]                cfg_idx,
   input  logic [31:0]               cfg_wdata,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [ROW_W+STK_W+10:0]   in_addr,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [ROW_W+STK_W+13:0]   out_addr
);

   // The interleaved output order is fixed for these two widths.
   localparam int COL_W    = 5;
   localparam int BANK_W   = 4;
   localparam int BXOR_W   = 6;
   localparam int COL_LSB  = 1;
   localparam int BANK_LSB = COL_LSB + COL_W;
   localparam int ROW_LSB  = BANK_LSB + BANK_W;
   localparam int PC_POS   = ROW_LSB + ROW_W;
   localparam int STK_LSB  = PC_POS + 1;
   localparam int IN_W     = STK_LSB + STK_W;
   localparam int OUT_ROW  = ROW_W - 1;
   localparam int OUT_W    = 15 + OUT_ROW + STK_W;

   generate
      if (IN_W != ROW_W + STK_W + 11) begin : g_bad_in_w
         $error("dram_addr_normalizer: input width mismatch");
      end
      if (OUT_W != ROW_W + STK_W + 14) begin : g_bad_out_w
         $error("dram_addr_normalizer: output width mismatch");
      end
      if (ROW_W < 2 || STK_W < 1) begin : g_bad_fields
         $error("dram_addr_normalizer: field widths too small");
      end
   endgenerate

   hash_word_t [BANK_W-1:0] bank_hash;
   hash_word_t              pc_hash;
   logic [BXOR_W-1:0]       bank_xor;

   adn_cfg_regs #(
      .NUM_BANK_HASH (BANK_W),
      .IDX_W         (3),
      .DATA_W        (32),
      .BXOR_W        (BXOR_W)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (cfg_we),
      .idx_i       (cfg_idx),
      .wdata_i     (cfg_wdata),
      .bank_hash_o (bank_hash),
      .pc_hash_o   (pc_hash),
      .bank_xor_o  (bank_xor)
   );

   logic [COL_W-1:0]  f_col;
   logic [BANK_W-1:0] f_bank;
   logic [ROW_W-1:0]  f_row;
   logic              f_pc;
   logic [STK_W-1:0]  f_stk;
   assign f_col  = in_addr[COL_LSB  +: COL_W];
   assign f_bank = in_addr[BANK_LSB +: BANK_W];
   assign f_row  = in_addr[ROW_LSB  +: ROW_W];
   assign f_pc   = in_addr[PC_POS];
   assign f_stk  = in_addr[STK_LSB  +: STK_W];

   logic [BANK_W-1:0] clean_bank;
   logic              clean_pc;

   adn_dehash #(
      .NUM_BANK_HASH (BANK_W),
      .COL_W         (COL_W),
      .ROW_W         (ROW_W),
      .STK_W         (STK_W),
      .BXOR_W        (BXOR_W)
   ) u_dehash (
      .col_i       (f_col),
      .row_i       (f_row),
      .bank_i      (f_bank),
      .pc_i        (f_pc),
      .stk_i       (f_stk),
      .bank_hash_i (bank_hash),
      .pc_hash_i   (pc_hash),
      .bank_xor_i  (bank_xor),
      .bank_o      (clean_bank),
      .pc_o        (clean_pc)
   );

   logic [OUT_W-1:0] packed_addr;
   assign packed_addr = {f_stk, f_row[OUT_ROW-1:0], f_col[4], clean_bank[1:0],
                         clean_bank[3:2], f_col[3:2], clean_pc, f_col[1:0], 5'b0};

   logic accept;
   logic valid_q;
   logic [OUT_W-1:0] addr_q;

   assign in_ready = !valid_q || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
      end else if (accept) begin
         valid_q <= 1'b1;
         addr_q  <= packed_addr;
      end else if (out_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign out_valid = valid_q;
   assign out_addr  = addr_q;

   logic any_en;
   always_comb begin
      any_en = pc_hash.en;
      for (int i = 0; i < BANK_W; i++) any_en = any_en | bank_hash[i].en;
   end

   p_result_follows_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);

   p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

   p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // Zero bit of the request never reaches the result; low bits stay clear.
   p_low_bits_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_addr[0]) |=> (out_addr[4:0] == 5'b0));

   p_plain_repack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !any_en) |=>
         ((out_addr[13:10] == {$past(in_addr[BANK_LSB +: 2]), $past(in_addr[BANK_LSB+2 +: 2])})
          && (out_addr[7] == $past(in_addr[PC_POS]))));

endmodule

// File: tb/dram_addr_normalizer_tb.sv
module dram_addr_normalizer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [27:0] in_addr = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [30:0] out_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dram_addr_normalizer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_addr   (in_addr),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_addr  (out_addr)
   );

   // Shadow of the configuration, kept from the write rules of R7.
   logic [31:0] sh_bank [4];
   logic [31:0] sh_pc;
   logic [5:0]  sh_bx;

   // Plain repack table, all hashing off (R1, R2).
   localparam logic [58:0] VEC [11] = '{
      {28'h0000000, 31'h00000000},
      {28'h0000002, 31'h00000020},
      {28'h0000040, 31'h00001000},
      {28'h0000100, 31'h00000400},
      {28'h0000400, 31'h00008000},
      {28'h1000000, 31'h00000000},
      {28'h2000000, 31'h00000080},
      {28'hC000000, 31'h60000000},
      {28'h0000020, 31'h00004000},
      {28'h0000008, 31'h00000100},
      {28'hFFFFFFF, 31'h7FFFFFE0}
   };

   function automatic logic [30:0] model(input logic [27:0] a);
      logic [4:0]  c;
      logic [3:0]  b;
      logic [14:0] r;
      logic        p;
      logic [1:0]  s;
      logic [6:0]  e;
      logic        x;
      c = a[5:1]; b = a[9:6]; r = a[24:10]; p = a[25]; s = a[27:26];
      for (int i = 0; i < 4; i++) begin
         if (sh_bank[i][0]) begin
            x = 1'b0;
            for (int k = 0; k < 5; k++)  x = x ^ (c[k] & sh_bank[i][1+k]);
            for (int k = 0; k < 15; k++) x = x ^ (r[k] & sh_bank[i][14+k]);
            b[i] = b[i] ^ x;
         end
      end
      if (sh_pc[0]) begin
         e = {s, 1'b0, b};
         x = 1'b0;
         for (int k = 0; k < 5; k++)  x = x ^ (c[k] & sh_pc[1+k]);
         for (int k = 0; k < 15; k++) x = x ^ (r[k] & sh_pc[14+k]);
         for (int k = 0; k < 6; k++)  x = x ^ (e[k] & sh_bx[k]);
         p = p ^ x;
      end
      return {s, r[13:0], c[4], b[1:0], b[3:2], c[3:2], p, c[1:0], 5'b0};
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (idx)
         3'd0, 3'd1, 3'd2, 3'd3: sh_bank[idx] = d;
         3'd4: sh_pc = d;
         3'd5: sh_bx = d[5:0];
         default: ;
      endcase
   endtask

   task automatic clear_cfg();
      for (int i = 0; i < 6; i++) cfg_write(3'(i), 32'h0);
   endtask

   // Drive one request with out_ready high; result checked one edge later (R8).
   task automatic convert(input string req, input logic [27:0] a, input logic [30:0] exp);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, {31'b0, out_valid}, 32'h1);
      check(req, {1'b0, out_addr}, {1'b0, exp});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < 4; i++) sh_bank[i] = '0;
      sh_pc = '0; sh_bx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state (R8, R9)
      check("R8 reset out_valid", {31'b0, out_valid}, 32'h0);
      check("R9 reset in_ready", {31'b0, in_ready}, 32'h1);

      // Table walk: registers reset to zero, so pure repack (R7, R1, R2)
      for (int v = 0; v < 11; v++)
         convert("R2 repack table", VEC[v][58:31], VEC[v][30:0]);

      // R3: bank hash word 0, column mask bit for column[0]
      cfg_write(3'd0, 32'h0000_0003);
      convert("R3 bank0 flip", 28'h0000002, 31'h00001020);
      // R3: word 2 with row mask bit for row[0] -> bank[2] flips to out bit 10
      cfg_write(3'd0, 32'h0);
      cfg_write(3'd2, 32'h0000_4001);
      convert("R3 bank2 row flip", 28'h0000400, 31'h00008400);
      // R3: mask set but enable clear -> no flip
      cfg_write(3'd2, 32'h0000_4000);
      convert("R3 enable clear", 28'h0000400, 31'h00008000);
      clear_cfg();

      // R5: stack[0] sits at extended bank bit 5
      cfg_write(3'd4, 32'h0000_0001);
      cfg_write(3'd5, 32'h0000_0020);
      convert("R5 stack0 into pc hash", 28'h4000000, 31'h20000080);
      // R5: stack[1] beyond the 6-bit mask never contributes
      cfg_write(3'd5, 32'h0000_003F);
      convert("R5 stack1 ignored", 28'h8000000, 31'h40000000);
      clear_cfg();

      // R4: pc hash sees de-hashed bank[0]
      cfg_write(3'd0, 32'h0000_0003);
      cfg_write(3'd4, 32'h0000_0001);
      cfg_write(3'd5, 32'h0000_0001);
      convert("R4 pc uses dehashed bank", 28'h0000002, 31'h000010A0);
      clear_cfg();

      // R6: mask bits above field width have no effect
      cfg_write(3'd1, 32'hE000_3FC1);
      convert("R6 upper mask bits", 28'h000003E, 31'h00004360);
      clear_cfg();

      // R7: writes to indices 6 and 7 change nothing
      cfg_write(3'd6, 32'hFFFF_FFFF);
      cfg_write(3'd7, 32'hFFFF_FFFF);
      convert("R7 unused index", 28'h0000042, 31'h00001020);

      // R10: back-to-back acceptance
      @(negedge clk);
      in_valid = 1'b1; in_addr = 28'h0000040;
      @(negedge clk);
      check("R10 first result", {1'b0, out_addr}, 32'h00001000);
      check("R10 ready while streaming", {31'b0, in_ready}, 32'h1);
      in_addr = 28'h0000100;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 second result", {1'b0, out_addr}, 32'h00000400);
      check("R10 valid second", {31'b0, out_valid}, 32'h1);

      // R9: stall holds result and blocks new request
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1; in_addr = 28'h0000020;
      @(negedge clk);
      check("R9 stalled ready low", {31'b0, in_ready}, 32'h0);
      in_addr = 28'h2000000;
      @(negedge clk);
      check("R9 stalled hold", {1'b0, out_addr}, 32'h00004000);
      check("R9 stalled valid", {31'b0, out_valid}, 32'h1);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 after release", {1'b0, out_addr}, 32'h00000080);

      // Randomized masks and addresses against the model (R3, R4, R5, R6, R7)
      for (int n = 0; n < 60; n++) begin
         for (int w = 0; w < 4; w++) cfg_write(3'($urandom_range(0, 7)), $urandom);
         for (int m = 0; m < 8; m++) begin
            logic [27:0] a;
            a = 28'($urandom);
            convert("R4 random model", a, model(a));
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule